// File: doc/BRIEF.md
# Selectable-Operand Adder ALU

This block is the arithmetic unit of a small expression-reduction processor. It has no opcodes. A 2-bit operand selector and one carry-in bit pick a fixed pair of addends and feed them to a single 8-bit adder. With this one adder the block covers identity, increment, decrement, subtract-two, argument counting and argument-binding address sums. The operands come from four places: the value register, the source index, the 4-bit argument counter, and two constants.

The block drives two outputs in the same cycle. The full 8-bit sum goes to the address path. A databus word copies the low seven bits of the sum and takes its top bit straight from the value register, so the tag bit survives any arithmetic on a constant. The block is purely combinational and holds no state.

Top module: `argsum_alu`

## Requirements
- R1: With selector 00, operand A is zero and operand B is the value input, so `sum_o` equals V plus carry-in. Carry-in 0 gives identity and carry-in 1 gives increment.
- R2: With selector 01, operand A is the 4-bit argument counter zero-extended into the low nibble, and operand B is the masked value, so `sum_o` equals AC + V' + carry-in.
- R3: With selector 10, operand A is the constant 8'b1111_1110 and operand B is V, so `sum_o` is V-2 with carry-in 0 and V-1 with carry-in 1.
- R4: With selector 11, operand A is the source index and operand B is the masked value, so `sum_o` equals SI + V' + carry-in.
- R5: The masked value V' is formed from six ones in bits 7..2 and V[1:0] in bits 1..0. It therefore represents a negative offset from -4 to -1.
- R6: The sum is taken modulo 256 and the carry out of bit 7 is dropped. For example, V=8'hFF with selector 00 and carry-in 1 gives 8'h00.
- R7: `bus_o[7]` always equals V[7], and `bus_o[6:0]` equals `sum_o[6:0]`.
- R8: Both outputs follow any input change within the same cycle, with no clock or internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 2 | Operand-pair selector |
| cin_i | input | 1 | Carry into the adder |
| val_i | input | 8 | Value register contents |
| src_idx_i | input | 8 | Source index |
| argcnt_i | input | 4 | Argument counter |
| sum_o | output | 8 | Full adder result for address generation |
| bus_o | output | 8 | Databus word with the tag bit preserved |

## Verification
The address result and the databus word are produced in the same cycle from the same sum. They disagree only in the top bit, and only when V[7] differs from the sum's bit 7. The bench provokes this case with values such as V=8'h80 under decrement and V=8'h7F under increment. It also sets V[7] against binding sums that cross 8'h80. In each of these cycles it checks that the address output carries the arithmetic bit 7 and that the databus output keeps V[7]. All selector and carry pairs are then swept over random operands, and both outputs are compared with an integer model on every clock.

// File: rtl/argsum_alu.sv
module argsum_alu #(
  parameter int W    = 8,
  parameter int ACW  = 4,
  parameter int KEEP = 2
) (
  input  logic [1:0]   sel_i,
  input  logic         cin_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] src_idx_i,
  input  logic [ACW-1:0] argcnt_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] bus_o
);
  localparam logic [W-1:0] MINUS_TWO = {{(W-1){1'b1}}, 1'b0};
  localparam int           MASKW     = W - KEEP;

  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [W-1:0] vmask;

  assign vmask = {{MASKW{1'b1}}, val_i[KEEP-1:0]};

  always_comb begin
    case (sel_i)
      2'b00:   opa = '0;
      2'b01:   opa = {{(W-ACW){1'b0}}, argcnt_i};
      2'b10:   opa = MINUS_TWO;
      default: opa = src_idx_i;
    endcase
  end

  assign opb   = sel_i[0] ? vmask : val_i;
  assign sum_o = opa + opb + {{(W-1){1'b0}}, cin_i};
  assign bus_o = {val_i[W-1], sum_o[W-2:0]};

  always_comb begin
    if (!$isunknown({sel_i, cin_i, val_i, src_idx_i, argcnt_i})) begin
      assert_bus_tag_R7: assert (bus_o[W-1] == val_i[W-1]);
      assert_bus_low_R7: assert (bus_o[W-2:0] == sum_o[W-2:0]);
      if (sel_i == 2'b00 && !cin_i)
        assert_identity_R1: assert (sum_o == val_i);
      if (sel_i == 2'b10 && cin_i)
        assert_decrement_R3: assert (sum_o == val_i - W'(1));
      if (sel_i == 2'b10 && !cin_i)
        assert_minus_two_R3: assert (sum_o + W'(2) == val_i);
      if (sel_i == 2'b01)
        assert_argcount_R2: assert (sum_o == W'(argcnt_i) + W'(val_i[KEEP-1:0])
                                    - W'(1 << KEEP) + W'(cin_i));
      if (sel_i == 2'b11)
        assert_binding_R4: assert (sum_o == src_idx_i + W'(val_i[KEEP-1:0])
                                   - W'(1 << KEEP) + W'(cin_i));
    end
  end
endmodule

// File: tb/argsum_alu_bench.sv
module argsum_alu_bench;
  logic       clk = 1'b0;
  logic [1:0] sel;
  logic       cin;
  logic [7:0] v, si, sum_w, bus_w;
  logic [3:0] ac;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  argsum_alu u_argsum_alu (
    .sel_i(sel), .cin_i(cin), .val_i(v), .src_idx_i(si),
    .argcnt_i(ac), .sum_o(sum_w), .bus_o(bus_w)
  );

  function automatic int ref_sum(int s, int c, int vv, int sx, int a);
    int opa, opb;
    int vp;
    vp = 252 + (vv % 4);
    case (s)
      0: begin opa = 0;   opb = vv; end
      1: begin opa = a;   opb = vp; end
      2: begin opa = 254; opb = vv; end
      default: begin opa = sx; opb = vp; end
    endcase
    return (opa + opb + c) % 256;
  endfunction

  task automatic apply(input int s, input int c, input int vv, input int sx,
                       input int a, input string rq);
    int es, eb;
    @(posedge clk);
    #1;
    sel = 2'(s); cin = 1'(c); v = 8'(vv); si = 8'(sx); ac = 4'(a);
    es = ref_sum(s, c, vv, sx, a);
    eb = (vv >= 128 ? 128 : 0) + (es % 128);
    @(negedge clk);
    n_run++;
    if (int'(sum_w) != es) begin
      n_fail++;
      $display("FAIL %s sum_o sel=%0d cin=%0d: actual %0h expected %0h", rq, s, c, sum_w, es);
    end
    n_run++;
    if (int'(bus_w) != eb) begin
      n_fail++;
      $display("FAIL %s/R7 bus_o sel=%0d cin=%0d: actual %0h expected %0h", rq, s, c, bus_w, eb);
    end
  endtask

  initial begin
    sel = 0; cin = 0; v = 0; si = 0; ac = 0;
    // all-zero inputs give zero outputs
    apply(0, 0, 0, 0, 0, "R1");
    apply(0, 0, 8'h5A, 8'h33, 4, "R1");
    apply(0, 1, 8'h7F, 0, 0, "R1");      // bus keeps 0, sum 80
    apply(0, 1, 8'hFF, 0, 0, "R6");      // wrap to 00
    apply(1, 0, 8'h03, 0, 4'hF, "R2");   // 15 + (-1) = 14
    apply(1, 0, 8'h00, 0, 4'h0, "R5");   // -4 => FC
    apply(1, 1, 8'h81, 0, 4'h2, "R2");
    apply(2, 0, 8'h00, 0, 0, "R3");      // FE, bus 7E
    apply(2, 1, 8'h80, 0, 0, "R3");      // 7F, bus FF
    apply(2, 1, 8'h00, 0, 0, "R6");      // FF
    apply(3, 0, 8'h02, 8'h10, 0, "R4");  // 10 - 2 = 0E
    apply(3, 0, 8'h80, 8'h81, 0, "R4");  // 81-4 = 7D, bus FD
    apply(3, 0, 8'h03, 8'h00, 0, "R6");  // FF
    apply(3, 1, 8'hFC, 8'h7F, 9, "R5");  // 7F-4+1
    // R8: every selector/carry pair over random operands, one per cycle
    for (int k = 0; k < 400; k++) begin
      for (int p = 0; p < 8; p++) begin
        apply(p / 2, p % 2, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 15)), "R8");
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule